// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is a two-wire serial bus slave that owns one 7-bit setting for a 128-step resistive divider. The divider output runs from 0 V relative to the low terminal at code 0 up to one step below the high-terminal voltage at code 127. The block samples the bus clock and data lines with the system clock and finds start and stop conditions. It compares the first byte of each transaction against its own 7-bit address, which a 2-bit strap picks from a fixed set. If the address matches, the block acknowledges the byte.

After a write address, every following byte loads the setting. The block keeps no register pointer, so a transaction may update the setting any number of times. After a read address, the block returns the setting on every byte until the master answers with a not-acknowledge. The bus side has no data stream and no back-pressure: the block never stretches the clock. The only outputs are the setting and an open-drain pull-low enable for the data line.

Top module: `wiper_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it, the wiper code is 64 (midscale) and the data pull-low enable is 0.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A start at any point, including partway through a byte, restarts address reception. A stop returns the block to idle and leaves the wiper unchanged.
- R3: The first byte after a start carries a 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). The own address is 0x2C for strap 0, 0x2D for strap 1, 0x2E for strap 2 and 0x2C for strap 3. On a match, the block pulls the data line low during the ninth clock pulse.
- R4: When the address does not match, the block drives nothing and does not change the wiper until the next start.
- R5: In write mode, each byte has eight data bits and then an acknowledge pulse. Bit 7 of the byte is ignored and bits 6:0 load the wiper. The block acknowledges each data byte, and the new code shows on the wiper output before the acknowledge pulse goes high.
- R6: Within one write transaction, every further data byte overwrites the wiper again.
- R7: In read mode, each byte returns the wiper code MSB first with bit 7 at 0. The block keeps sending bytes while the master acknowledges (data low on the ninth pulse). After a not-acknowledge it releases the line and waits for a stop or start.
- R8: The pull-low enable changes only while the clock line is low. The block only pulls the line low and never drives it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 2 | Strap that selects the own address |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper | output | 7 | Current divider code |

## Verification
The bench aims at a start that arrives three bits into a data byte. A design that failed to restart would shift those stale bits into the next address and miss the match. A stop in the same position must leave the code unchanged; a design that loaded on a partial byte would change it. Reads are tested with a run of master acknowledges ending in a not-acknowledge. A design that ignored the not-acknowledge would keep pulling the line and corrupt the stop. Written bytes with bit 7 set catch a design that lets that bit into the code or returns it on a read. The strap value 3 catches an address table that decodes only three entries.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } wsl_state_e;

  // Bus events in the system clock domain
  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } wsl_bus_ev_t;

endpackage

// File: rtl/wsl_line_sync.sv
module wsl_line_sync
  import wsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output wsl_bus_ev_t ev
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  // Synchronizer chain, one flop per stage; idle bus level is high
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev.scl      = scl_s;
    ev.sda      = sda_s;
    ev.scl_rise = scl_s & ~scl_q;
    ev.scl_fall = ~scl_s & scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/wsl_wiper_reg.sv
module wsl_wiper_reg #(
  parameter int WIPER_W = 7,
  parameter logic [WIPER_W-1:0] RESET_CODE = 7'd64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [WIPER_W-1:0] load_val,
  output logic [WIPER_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= RESET_CODE;
    else if (load) code <= load_val;
  end

endmodule

// File: rtl/wsl_proto_fsm.sv
module wsl_proto_fsm
  import wsl_pkg::*;
#(
  parameter int WIPER_W = 7,
  parameter int ADDR_W  = 7,
  parameter logic [ADDR_W-1:0] ADDR_OPT0 = 7'h2C,
  parameter logic [ADDR_W-1:0] ADDR_OPT1 = 7'h2D,
  parameter logic [ADDR_W-1:0] ADDR_OPT2 = 7'h2E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wsl_bus_ev_t        ev,
  input  logic [1:0]         addr_sel,
  input  logic [WIPER_W-1:0] wiper,
  output logic               wr_en,
  output logic [WIPER_W-1:0] wr_data,
  output logic               sda_pull
);

  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam int PAD_W  = DATA_W - WIPER_W;

  wsl_state_e        state;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              rd_mode;
  logic              master_ack;
  logic [ADDR_W-1:0] own_addr;
  logic              addr_hit;

  always_comb begin
    case (addr_sel)
      2'd1:    own_addr = ADDR_OPT1;
      2'd2:    own_addr = ADDR_OPT2;
      default: own_addr = ADDR_OPT0;
    endcase
  end

  assign addr_hit = (shreg[DATA_W-1:DATA_W-ADDR_W] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      txreg      <= '0;
      bitcnt     <= '0;
      rd_mode    <= 1'b0;
      master_ack <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev.start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
      end else if (ev.stop) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (ev.scl_rise) begin
              shreg  <= {shreg[DATA_W-2:0], ev.sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (ev.scl_fall && bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state   <= ST_ADDR_ACK;
                  rd_mode <= shreg[0];
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg[WIPER_W-1:0];
                state   <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (ev.scl_rise) begin
              bitcnt <= 1'b1;
            end else if (ev.scl_fall && bitcnt != '0) begin
              bitcnt <= '0;
              if (state == ST_ADDR_ACK && rd_mode) begin
                state <= ST_RD;
                txreg <= {{PAD_W{1'b0}}, wiper};
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (ev.scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (ev.scl_fall && bitcnt != '0) begin
              if (bitcnt == LAST_BIT) begin
                state  <= ST_RD_ACK;
                bitcnt <= '0;
              end else begin
                txreg <= {txreg[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (ev.scl_rise) begin
              bitcnt     <= 1'b1;
              master_ack <= ~ev.sda;
            end else if (ev.scl_fall && bitcnt != '0) begin
              bitcnt <= '0;
              if (master_ack) begin
                state <= ST_RD;
                txreg <= {{PAD_W{1'b0}}, wiper};
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
      ST_RD:                  sda_pull = ~txreg[DATA_W-1];
      default:                sda_pull = 1'b0;
    endcase
  end

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST_BIT); // R5

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> (state == ST_ADDR && bitcnt == '0)); // R2

  AST_NOMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && ev.scl_fall && bitcnt == LAST_BIT && !addr_hit)
      |=> (state == ST_IDLE)); // R4

  AST_READ_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && bitcnt == '0) |-> !txreg[DATA_W-1]); // R7

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop))
      |-> $stable(sda_pull)); // R8

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wsl_pkg::*;
#(
  parameter int WIPER_W     = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_OPT0 = 7'h2C,
  parameter logic [6:0] ADDR_OPT1 = 7'h2D,
  parameter logic [6:0] ADDR_OPT2 = 7'h2E
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [1:0]         addr_sel,
  output logic               sda_pull,
  output logic [WIPER_W-1:0] wiper
);

  localparam logic [WIPER_W-1:0] RESET_CODE = WIPER_W'(1 << (WIPER_W - 1));

  wsl_bus_ev_t        ev;
  logic               wr_en;
  logic [WIPER_W-1:0] wr_data;

  wsl_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  wsl_proto_fsm #(
    .WIPER_W   (WIPER_W),
    .ADDR_W    (7),
    .ADDR_OPT0 (ADDR_OPT0),
    .ADDR_OPT1 (ADDR_OPT1),
    .ADDR_OPT2 (ADDR_OPT2)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .addr_sel (addr_sel),
    .wiper    (wiper),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_pull (sda_pull)
  );

  wsl_wiper_reg #(.WIPER_W(WIPER_W), .RESET_CODE(RESET_CODE)) u_wiper (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (wr_data),
    .code     (wiper)
  );

  AST_RESET_MIDSCALE: assert property (@(posedge clk)
    !rst_n |=> (wiper == RESET_CODE && !sda_pull)); // R1

  AST_WIPER_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> $past(ev.scl_fall, 2)); // R5

endmodule

// File: tb/wiper_i2c_slave_tb.sv
module wiper_i2c_slave_tb;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_sel = 2'd0;
  logic       sda_pull;
  logic [6:0] wiper;
  logic       sda_line;

  int checks = 0;
  int failures = 0;
  int drive_viol = 0;
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;
  logic mon_en = 1'b0;
  logic [6:0] exp_wiper = 7'd64;

  assign sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  wiper_i2c_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .addr_sel (addr_sel),
    .sda_pull (sda_pull),
    .wiper    (wiper)
  );

  function automatic logic [6:0] exp_addr(input logic [1:0] s);
    case (s)
      2'd1:    return 7'h2D;
      2'd2:    return 7'h2E;
      default: return 7'h2C;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R8 monitor: drive must not change while SCL is high
  always @(negedge clk) begin
    if (mon_en && scl && prev_scl && sda_pull != prev_pull) drive_viol++;
    prev_scl  <= scl;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    void'($urandom(32'h5A17));
    tick(5);
    check(wiper == 7'd64, "R1 reset wiper", wiper, 64);
    check(sda_pull == 1'b0, "R1 reset pull", sda_pull, 0);
    rst_n = 1'b1;
    tick(5);
    mon_en = 1'b1;
    check(wiper == 7'd64, "R1 after reset", wiper, 64);

    // R3 and R5: each strap, write with bit 7 set
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      tick(Q);
      bus_start();
      send_byte({exp_addr(2'(s)), 1'b0}, ack);
      check(ack, "R3 address ack", ack, 1);
      send_byte(8'h80 | 8'(s * 17 + 3), ack);
      exp_wiper = 7'(s * 17 + 3);
      check(ack, "R5 data ack", ack, 1);
      check(wiper == exp_wiper, "R5 wiper load msb ignored", wiper, exp_wiper);
      bus_stop();
    end

    // R4: wrong address, no ack, no change
    addr_sel = 2'd1;
    bus_start();
    send_byte({7'h2C, 1'b0}, ack);
    check(!ack, "R4 foreign address", ack, 0);
    send_byte(8'h11, ack);
    check(!ack, "R4 no data ack", ack, 0);
    check(wiper == exp_wiper, "R4 wiper kept", wiper, exp_wiper);
    bus_stop();

    // R6: several bytes in one write
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'h20 + k * 9), ack);
      exp_wiper = 7'(8'h20 + k * 9);
      check(ack && wiper == exp_wiper, "R6 repeated write", wiper, exp_wiper);
    end
    bus_stop();

    // R7: repeated read, NACK on last
    bus_start();
    send_byte({7'h2D, 1'b1}, ack);
    check(ack, "R7 read address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(k != 2, rb);
      check(rb == {1'b0, exp_wiper}, "R7 read data", rb, {1'b0, exp_wiper});
    end
    check(sda_pull == 1'b0, "R7 released after nack", sda_pull, 0);
    bus_stop();

    // R2: stop mid byte leaves wiper
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    check(wiper == exp_wiper, "R2 stop mid byte", wiper, exp_wiper);

    // R2: repeated start mid byte restarts address reception
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    check(ack, "R2 restart address ack", ack, 1);
    send_byte(8'h05, ack);
    exp_wiper = 7'h05;
    check(wiper == exp_wiper, "R2 restart write", wiper, exp_wiper);
    bus_stop();

    // Random mix
    for (int it = 0; it < 24; it++) begin
      logic [1:0] s;
      logic       match;
      logic       rd;
      logic [6:0] a;
      int         n;
      s     = 2'($urandom % 4);
      match = ($urandom % 4) != 0;
      rd    = 1'($urandom % 2);
      n     = 1 + int'($urandom % 3);
      a     = match ? exp_addr(s) : (exp_addr(s) ^ 7'h10);
      addr_sel = s;
      tick(Q);
      bus_start();
      send_byte({a, rd}, ack);
      check(ack == match, "R3 random address", ack, match);
      if (!rd) begin
        for (int k = 0; k < n; k++) begin
          logic [7:0] d;
          d = 8'($urandom);
          send_byte(d, ack);
          if (match) exp_wiper = d[6:0];
          check(ack == match && wiper == exp_wiper, "R6 random write", wiper, exp_wiper);
        end
      end else if (match) begin
        for (int k = 0; k < n; k++) begin
          recv_byte(k != n - 1, rb);
          check(rb == {1'b0, exp_wiper}, "R7 random read", rb, {1'b0, exp_wiper});
        end
      end else begin
        recv_byte(1'b0, rb);
        check(rb == 8'hFF, "R4 random idle bus", rb, 8'hFF);
      end
      bus_stop();
      check(sda_pull == 1'b0, "R8 released after stop", sda_pull, 0);
    end

    check(drive_viol == 0, "R8 drive change while SCL high", drive_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule